// File: doc/BRIEF.md
# RGMII Receive Converter with In-Band Status

This block turns the double-data-rate RGMII receive interface into byte-wide GMII receive signals. Its inputs are the 4-bit receive data and the receive control line. Each has already been captured into a rising-edge half and a falling-edge half. Its outputs are the data byte, data valid, error, carrier sense and collision. All of its registers run on the receive clock from the PHY, and that clock is forwarded unchanged as the GMII receive clock.

At gigabit speed, one byte is formed on every clock from the two edge halves. At 100 and 10 Mbps, only the rising-edge nibbles carry data, and successive nibbles are paired into bytes. Between frames, the PHY places link status on the data lines. The block latches this status and uses it to produce collision and carrier sense, because no dedicated pins carry those signals. A parameter inserts one extra register stage in front of the GMII outputs.

Top module: `rgmii_rx_conv`

## Requirements
- R1: At gigabit speed, each clock with the rising control half high yields a valid byte one clock after capture (without the extra stage). Bits [3:0] come from the rising data half and bits [7:4] from the falling data half.
- R2: The error flag equals the falling control half XOR the rising control half. It is reported together with the byte it belongs to.
- R3: At 10/100 speed, rising-edge nibbles captured while the rising control half is high are paired, low nibble first. Valid pulses for one clock per completed byte, and error is set if either nibble carried an error. A single unpaired nibble at frame end is dropped.
- R4: The speed input uses 3'b011 for gigabit, 3'b100 for 100 Mbps and 3'b111 for 10 Mbps. Any other code is handled as gigabit.
- R5: When both control halves are low, the rising data nibble is latched as status: bit 0 is link, bits [2:1] are speed and bit 3 is full duplex. Status is not updated during a frame, and it is not updated when only the error condition is signalled (rising half low, falling half high).
- R6: Carrier sense is high from one clock after the rising control half goes high until one clock after it falls. Collision is high only during that same window, and only when the latched status shows half duplex.
- R7: An active-low receive reset clears all outputs and the latched status. Cleared status reads as half duplex.
- R8: With PIPE_EN=1, every GMII output except the clock arrives exactly one clock later than with PIPE_EN=0.
- R9: The GMII receive clock output equals the PHY receive clock at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx | input | 1 | Receive clock from the PHY |
| rst_rx_n | input | 1 | Active-low asynchronous receive reset |
| spd | input | 3 | Speed code |
| rxd_r | input | 4 | Receive data captured on the rising edge |
| rxd_f | input | 4 | Receive data captured on the falling edge |
| rxctl_r | input | 1 | Receive control captured on the rising edge |
| rxctl_f | input | 1 | Receive control captured on the falling edge |
| gmii_rx_clk | output | 1 | Forwarded receive clock |
| gmii_rxd | output | 8 | Received byte |
| gmii_rxdv | output | 1 | Byte valid |
| gmii_rxer | output | 1 | Receive error |
| gmii_crs | output | 1 | Carrier sense |
| gmii_col | output | 1 | Collision |

## Verification
The following properties are checked by assertions on every cycle:
- collision never appears without carrier sense;
- valid at 10/100 never holds for two clocks in a row;
- a gigabit capture with control high produces a valid stage byte on the next clock;
- the latched status stays frozen while a frame is active;
- reset leaves the outputs cleared.

The remaining behaviour can only be shown by the bench scenarios: that nibble order, error merging, dropping of a trailing half byte and status decoding (duplex, and the error-only case being ignored) give the right bytes, collision and carrier sense at each of the three speeds; the exact latency of the extra stage; and the recovery of status after a reset.

// File: rtl/rgmii_rx_conv.sv
module rgmii_rx_conv #(
  parameter bit PIPE_EN = 1'b1,
  parameter int NIB_W   = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk_rx,
  input  logic              rst_rx_n,
  input  logic [2:0]        spd,
  input  logic [NIB_W-1:0]  rxd_r,
  input  logic [NIB_W-1:0]  rxd_f,
  input  logic              rxctl_r,
  input  logic              rxctl_f,
  output logic              gmii_rx_clk,
  output logic [BYTE_W-1:0] gmii_rxd,
  output logic              gmii_rxdv,
  output logic              gmii_rxer,
  output logic              gmii_crs,
  output logic              gmii_col
);

  localparam logic [2:0] SPD_100 = 3'b100;
  localparam logic [2:0] SPD_10  = 3'b111;

  logic              dv_in, er_in, nib;
  logic              half, lo_er, act;
  logic [NIB_W-1:0]  lo, stat;
  logic [BYTE_W-1:0] st_d;
  logic              st_dv, st_er;
  logic              col_c;

  assign gmii_rx_clk = clk_rx;
  assign dv_in = rxctl_r;
  assign er_in = rxctl_f ^ rxctl_r;
  assign nib   = (spd == SPD_100) || (spd == SPD_10);
  assign col_c = act & ~stat[3];

  always_ff @(posedge clk_rx or negedge rst_rx_n) begin
    if (!rst_rx_n) begin
      half  <= 1'b0;
      lo    <= '0;
      lo_er <= 1'b0;
      act   <= 1'b0;
      stat  <= '0;
      st_d  <= '0;
      st_dv <= 1'b0;
      st_er <= 1'b0;
    end else begin
      act <= dv_in;
      if (!dv_in && !er_in) stat <= rxd_r;
      if (!nib) begin
        half  <= 1'b0;
        st_dv <= dv_in;
        st_er <= er_in;
        st_d  <= {rxd_f, rxd_r};
      end else if (!dv_in) begin
        half  <= 1'b0;
        st_dv <= 1'b0;
        st_er <= 1'b0;
      end else if (!half) begin
        half  <= 1'b1;
        lo    <= rxd_r;
        lo_er <= er_in;
        st_dv <= 1'b0;
        st_er <= 1'b0;
      end else begin
        half  <= 1'b0;
        st_d  <= {rxd_r, lo};
        st_dv <= 1'b1;
        st_er <= er_in | lo_er;
      end
    end
  end

  generate
    if (PIPE_EN) begin : g_pipe
      always_ff @(posedge clk_rx or negedge rst_rx_n) begin
        if (!rst_rx_n) begin
          gmii_rxd  <= '0;
          gmii_rxdv <= 1'b0;
          gmii_rxer <= 1'b0;
          gmii_crs  <= 1'b0;
          gmii_col  <= 1'b0;
        end else begin
          gmii_rxd  <= st_d;
          gmii_rxdv <= st_dv;
          gmii_rxer <= st_er;
          gmii_crs  <= act;
          gmii_col  <= col_c;
        end
      end
    end else begin : g_direct
      assign gmii_rxd  = st_d;
      assign gmii_rxdv = st_dv;
      assign gmii_rxer = st_er;
      assign gmii_crs  = act;
      assign gmii_col  = col_c;
    end
  endgenerate

  p_col_needs_crs_r6: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    gmii_col |-> gmii_crs);

  p_nib_spacing_r3: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    (nib && st_dv) |=> (!nib || !st_dv));

  p_gig_byte_r1: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    (!nib && rxctl_r) |=> (st_dv && st_d[NIB_W-1:0] == $past(rxd_r)));

  p_stat_frozen_r5: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    act |-> $stable(stat));

  always @(posedge clk_rx) begin
    if (!rst_rx_n) begin
      p_reset_clear_r7: assert (!gmii_rxdv && !gmii_rxer && !gmii_crs && !gmii_col);
    end
  end

endmodule

// File: tb/rgmii_rx_conv_tb_top.sv
module rgmii_rx_conv_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] spd = 3'b011;
  logic [3:0] rxd_r = '0, rxd_f = '0;
  logic ctl_r = 1'b0, ctl_f = 1'b0;
  logic rclk, dv, er, crs, col;
  logic [7:0] d;
  int checks = 0, errors = 0, cyc = 0;
  logic [8:0] exp_q[$];

  always #5 clk = ~clk;

  rgmii_rx_conv #(.PIPE_EN(1'b1)) dut_i (
    .clk_rx(clk), .rst_rx_n(rst_n), .spd(spd), .rxd_r(rxd_r), .rxd_f(rxd_f),
    .rxctl_r(ctl_r), .rxctl_f(ctl_f), .gmii_rx_clk(rclk), .gmii_rxd(d),
    .gmii_rxdv(dv), .gmii_rxer(er), .gmii_crs(crs), .gmii_col(col));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && dv) begin
      if (exp_q.size() == 0) chk("R1/R3 unexpected byte", {23'd0, er, d}, 32'h1ff);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk("R1/R2/R3 scoreboard", {23'd0, er, d}, {23'd0, e});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drive(input logic [3:0] r, input logic [3:0] f, input logic cr, input logic cf);
    @(negedge clk);
    rxd_r = r; rxd_f = f; ctl_r = cr; ctl_f = cf;
  endtask

  task automatic idle_stat(input logic [3:0] s, input int n);
    for (int i = 0; i < n; i++) drive(s, 4'h0, 1'b0, 1'b0);
  endtask

  task automatic gig_frame(input int n, input logic [7:0] seed, input int err_at, input logic exp_col);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      logic e;
      b = seed + 8'(i * 37);
      e = (i == err_at);
      exp_q.push_back({e, b});
      @(negedge clk);
      if (i >= 2) begin
        chk("R6 crs in frame", {31'd0, crs}, 32'd1);
        chk("R6 col duplex", {31'd0, col}, {31'd0, exp_col});
      end
      rxd_r = b[3:0]; rxd_f = b[7:4]; ctl_r = 1'b1; ctl_f = ~e;
    end
  endtask

  task automatic nib_frame(input int n, input logic [7:0] seed, input int err_nib, input logic exp_col, input bit extra);
    int total;
    total = 2 * n + (extra ? 1 : 0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = seed + 8'(i * 53);
      exp_q.push_back({(err_nib / 2 == i), b});
    end
    for (int k = 0; k < total; k++) begin
      logic [7:0] b;
      b = seed + 8'((k / 2) * 53);
      @(negedge clk);
      if (k >= 2) begin
        chk("R6 crs in nibble frame", {31'd0, crs}, 32'd1);
        chk("R6 col nibble frame", {31'd0, col}, {31'd0, exp_col});
      end
      rxd_r = (k % 2 == 0) ? b[3:0] : b[7:4];
      rxd_f = 4'hA; ctl_r = 1'b1; ctl_f = (k != err_nib);
    end
  endtask

  task automatic drain;
    idle_stat(rxd_r, 4);
    chk("R6 crs low after frame", {31'd0, crs}, 32'd0);
    chk("R3/R1 queue drained", exp_q.size(), 32'd0);
    exp_q.delete();
  endtask

  initial begin
    #1;
    chk("R9 clock fwd low", {31'd0, rclk}, {31'd0, clk});
    repeat (3) @(negedge clk);
    chk("R7 reset outputs", {27'd0, dv, er, crs, col, |d}, 32'd0);
    rst_n = 1'b1;
    #2 chk("R9 clock fwd high", {31'd0, rclk}, {31'd0, clk});

    idle_stat(4'b1101, 3);
    // R8 latency: one capture clock plus one pipeline clock
    exp_q.push_back({1'b0, 8'h5C});
    drive(4'hC, 4'h5, 1'b1, 1'b1);
    drive(4'b1101, 4'h0, 1'b0, 1'b0);
    chk("R8 not yet valid", {31'd0, dv}, 32'd0);
    @(negedge clk);
    chk("R8 valid after two clocks", {23'd0, dv, d}, {23'd0, 1'b1, 8'h5C});
    drain();

    // R1/R2 gigabit, full duplex, error on byte 3
    idle_stat(4'b1101, 3);
    gig_frame(8, 8'h13, 3, 1'b0);
    drain();

    // R4 unknown code behaves as gigabit
    spd = 3'b000;
    idle_stat(4'b1101, 2);
    gig_frame(4, 8'hE1, -1, 1'b0);
    drain();

    // R3 100 Mbps, half duplex status, error on high nibble of byte 1, trailing nibble dropped
    spd = 3'b100;
    idle_stat(4'b0011, 3);
    nib_frame(4, 8'h2B, 3, 1'b1, 1'b1);
    drain();

    // R3/R4 10 Mbps full duplex
    spd = 3'b111;
    idle_stat(4'b1001, 3);
    nib_frame(3, 8'h90, 0, 1'b0, 1'b0);
    drain();

    // R5 error-only idle must not overwrite full-duplex status
    spd = 3'b011;
    idle_stat(4'b1101, 2);
    drive(4'h0, 4'h0, 1'b0, 1'b1);
    drive(4'h0, 4'h0, 1'b0, 1'b1);
    gig_frame(4, 8'h44, -1, 1'b0);
    drain();

    // R5 half-duplex status then collision
    idle_stat(4'b0101, 2);
    gig_frame(5, 8'h70, -1, 1'b1);
    drain();

    // R7 reset clears latched status (full duplex -> half)
    idle_stat(4'b1101, 2);
    @(negedge clk);
    ctl_r = 1'b1; ctl_f = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7 outputs during reset", {27'd0, dv, er, crs, col, |d}, 32'd0);
    ctl_r = 1'b0; ctl_f = 1'b0; rxd_r = 4'h0;
    exp_q.delete();
    @(negedge clk);
    ctl_r = 1'b1; ctl_f = 1'b1; rxd_r = 4'h7; rxd_f = 4'h7;
    rst_n = 1'b1;
    exp_q.push_back({1'b0, 8'h77});
    exp_q.push_back({1'b0, 8'h77});
    exp_q.push_back({1'b0, 8'h77});
    repeat (2) @(negedge clk);
    chk("R7 status cleared gives collision", {31'd0, col}, 32'd1);
    drive(4'h0, 4'h0, 1'b0, 1'b0);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule